// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block reports how fast a fan turns. It does not count tachometer pulses over a fixed time, because a slow fan would need seconds to produce enough of them. It measures time instead. After a qualifying rising edge on the tachometer line, it counts strobes of a reference tick until a programmable number of further rising edges has arrived. The count is 16 bits wide, and a larger count means a slower fan. When that edge is reached, the count is latched as the reading. The window that just closed ends on an edge, and that same edge opens the next window. Readings therefore follow each other with no gap.

A fan that stops produces no edges. The counter then saturates at full scale and reports 0xFFFF, which stands for a stalled or nearly stopped fan. Each new reading is compared with a minimum-speed limit. A reading above the limit raises a slow-fan fault that holds until the next reading.

The raw tachometer input passes through a synchronizer and then a level filter, so short spikes never count as edges. Software can read the value one byte at a time. Reading the low byte captures the matching high byte, so a 16-bit value read in two accesses stays coherent while measurements continue.

Top module: `fan_period_meter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `reading`, `reading_valid`, `slow_fault` and `byte_out` are all zero.
- R2: A window opens on a qualifying rising edge. It closes on the N-th qualifying rising edge after that. `reading` is the number of `ref_tick` strobes seen in the cycles after the opening edge, up to and including the cycle of the closing edge. The closing edge opens the next window at once.
- R3: `pulse_sel` is sampled when a window opens and sets N as follows: 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 3, 2'b11 gives 4.
- R4: If the count reaches 16'hFFFF before the closing edge arrives, the window ends with a reading of 16'hFFFF. This also applies while waiting for an opening edge.
- R5: `slow_fault` is updated together with each new reading. It is 1 exactly when that reading is strictly greater than `min_limit`.
- R6: `reading_valid` is high for one cycle per finished window. `reading` changes only in that cycle and holds its value between readings.
- R7: A tachometer level that lasts fewer than FILT_LEN clock cycles (4 by default) is ignored. It neither closes nor opens a window.
- R8: A one-cycle pulse on `rd_lo` loads `byte_out` with `reading[7:0]` on the next clock and captures `reading[15:8]`. The next `rd_hi` pulse returns the captured byte, even if newer readings have arrived since. An `rd_hi` pulse with no capture pending returns the live `reading[15:8]`.
- R9: Only clock cycles that carry `ref_tick` advance the count. With one strobe every D cycles, the reading equals the window length in cycles divided by D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tach_raw | input | 1 | Asynchronous tachometer line from the fan |
| ref_tick | input | 1 | One-cycle reference time strobe |
| pulse_sel | input | 2 | Edges per window, coded as in R3 |
| min_limit | input | 16 | Largest reading that is not a fault |
| rd_lo | input | 1 | Low-byte read strobe |
| rd_hi | input | 1 | High-byte read strobe |
| reading | output | 16 | Latched window count |
| reading_valid | output | 1 | One-cycle new-reading strobe |
| slow_fault | output | 1 | Reading above limit |
| byte_out | output | 8 | Byte returned by the last read strobe |

## Verification
The hardest state to reach is the coherent-read case, where a newer reading has replaced the one whose low byte was read and the two readings have different high bytes. The stimulus reads the low byte of a short window. It then changes the tachometer period so that later windows are much longer, waits out two full readings, and only then reads the high byte. The stall path needs a silent line for a full 65535 strobes, so it is exercised once, at the end of the run. Spikes two cycles wide are placed inside the low phase, where they would otherwise add a rising edge.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;
  localparam int DEF_CNT_W = 16;
  localparam int DEF_SEL_W = 2;
  typedef enum logic [0:0] {WIN_SEEK = 1'b0, WIN_SPAN = 1'b1} win_state_t;
endpackage

// File: rtl/tach_conditioner.sv
module tach_conditioner #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tach_raw,
  output logic rise
);
  localparam int RW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [RW-1:0]          run_q;
  logic                   clean_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= tach_raw;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], tach_raw};
      end
    end
  endgenerate

  // accept a new level only after FILT_LEN consecutive samples disagree
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      clean_q <= 1'b0;
      rise    <= 1'b0;
    end else begin
      rise <= 1'b0;
      if (synced == clean_q) begin
        run_q <= '0;
      end else if (run_q == RW'(FILT_LEN - 1)) begin
        run_q   <= '0;
        clean_q <= synced;
        rise    <= synced;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // R7
  filt_follows_input_chk: assert property (@(posedge clk) disable iff (rst)
    (clean_q != $past(clean_q)) |-> ($past(synced) == clean_q));

  // R7
  rise_only_high_chk: assert property (@(posedge clk) disable iff (rst)
    rise |-> clean_q);
endmodule

// File: rtl/period_counter.sv
module period_counter
  import fan_tach_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W,
  parameter int SEL_W = DEF_SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic             ref_tick,
  input  logic [SEL_W-1:0] pulse_sel,
  output logic             done,
  output logic [CNT_W-1:0] result
);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  win_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;
  logic [SEL_W-1:0] edges;
  logic [SEL_W-1:0] target;
  logic             sat;

  always_comb begin
    cnt_inc = (ref_tick && cnt != FULL) ? cnt + 1'b1 : cnt;
    sat     = (cnt_inc == FULL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= WIN_SEEK;
      cnt    <= '0;
      edges  <= '0;
      target <= '0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        WIN_SEEK: begin
          if (rise) begin
            state  <= WIN_SPAN;
            cnt    <= '0;
            edges  <= '0;
            target <= pulse_sel;
          end else if (sat) begin
            done   <= 1'b1;
            result <= FULL;
            cnt    <= '0;
          end else begin
            cnt <= cnt_inc;
          end
        end
        default: begin
          if (rise && edges == target) begin
            done   <= 1'b1;
            result <= cnt_inc;
            cnt    <= '0;
            edges  <= '0;
            target <= pulse_sel;
          end else if (sat) begin
            done   <= 1'b1;
            result <= FULL;
            state  <= WIN_SEEK;
            cnt    <= '0;
          end else begin
            cnt <= cnt_inc;
            if (rise) edges <= edges + 1'b1;
          end
        end
      endcase
    end
  end

  // R4
  sat_restarts_chk: assert property (@(posedge clk) disable iff (rst)
    sat |=> (cnt == '0 && done));

  // R2
  edges_bounded_chk: assert property (@(posedge clk) disable iff (rst)
    (state == WIN_SPAN) |-> (edges <= target));
endmodule

// File: rtl/fan_result_latch.sv
module fan_result_latch #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done,
  input  logic [CNT_W-1:0] result,
  input  logic [CNT_W-1:0] min_limit,
  input  logic             rd_lo,
  input  logic             rd_hi,
  output logic [CNT_W-1:0] reading,
  output logic             valid,
  output logic             fault,
  output logic [7:0]       byte_out
);
  logic [7:0] hi_shadow;
  logic       hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      reading   <= '0;
      valid     <= 1'b0;
      fault     <= 1'b0;
      byte_out  <= '0;
      hi_shadow <= '0;
      hold      <= 1'b0;
    end else begin
      valid <= done;
      if (done) begin
        reading <= result;
        fault   <= (result > min_limit);
      end
      if (rd_lo) begin
        byte_out  <= reading[7:0];
        hi_shadow <= 8'(reading >> 8);
        hold      <= 1'b1;
      end else if (rd_hi) begin
        byte_out <= hold ? hi_shadow : 8'(reading >> 8);
        hold     <= 1'b0;
      end
    end
  end

  // R6
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R6
  reading_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(reading));

  // R5
  fault_compare_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (fault == ($past(result) > $past(min_limit))));

  // R8
  shadow_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && !rd_lo) |=> $stable(hi_shadow));
endmodule

// File: rtl/fan_period_meter.sv
module fan_period_meter
  import fan_tach_pkg::*;
#(
  parameter int CNT_W       = DEF_CNT_W,
  parameter int SEL_W       = DEF_SEL_W,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tach_raw,
  input  logic             ref_tick,
  input  logic [SEL_W-1:0] pulse_sel,
  input  logic [CNT_W-1:0] min_limit,
  input  logic             rd_lo,
  input  logic             rd_hi,
  output logic [CNT_W-1:0] reading,
  output logic             reading_valid,
  output logic             slow_fault,
  output logic [7:0]       byte_out
);
  logic             rise;
  logic             done;
  logic [CNT_W-1:0] result;

  tach_conditioner #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_cond (
    .clk(clk), .rst(rst), .tach_raw(tach_raw), .rise(rise)
  );

  period_counter #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_cnt (
    .clk(clk), .rst(rst), .rise(rise), .ref_tick(ref_tick),
    .pulse_sel(pulse_sel), .done(done), .result(result)
  );

  fan_result_latch #(.CNT_W(CNT_W)) u_lat (
    .clk(clk), .rst(rst), .done(done), .result(result),
    .min_limit(min_limit), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .reading(reading), .valid(reading_valid), .fault(slow_fault),
    .byte_out(byte_out)
  );
endmodule

// File: tb/fan_period_meter_test.sv
module fan_period_meter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tach_raw = 1'b0;
  logic        ref_tick = 1'b0;
  logic [1:0]  pulse_sel = 2'b01;
  logic [15:0] min_limit = 16'hFFFF;
  logic        rd_lo = 1'b0;
  logic        rd_hi = 1'b0;
  logic [15:0] reading;
  logic        reading_valid;
  logic        slow_fault;
  logic [7:0]  byte_out;

  int total = 0;
  int fails = 0;
  int tper = 0;
  int tick_div = 1;
  bit glitch_en = 1'b0;
  bit finished = 1'b0;

  fan_period_meter uut (
    .clk(clk), .rst(rst), .tach_raw(tach_raw), .ref_tick(ref_tick),
    .pulse_sel(pulse_sel), .min_limit(min_limit), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .reading(reading), .reading_valid(reading_valid), .slow_fault(slow_fault),
    .byte_out(byte_out)
  );

  always #5 clk = ~clk;

  // reference strobe: one cycle in every tick_div
  initial begin
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      ref_tick = (ph == 0);
      ph = (ph + 1 >= tick_div) ? 0 : ph + 1;
    end
  end

  // tachometer waveform: rises exactly tper cycles apart, optional spike in low phase
  initial begin
    forever begin
      if (tper == 0) begin
        tach_raw = 1'b0;
        @(negedge clk);
      end else begin
        int p;
        int lo;
        p = tper;
        lo = p - p / 2;
        tach_raw = 1'b1;
        repeat (p / 2) @(negedge clk);
        tach_raw = 1'b0;
        if (glitch_en && lo >= 10) begin
          repeat (3) @(negedge clk);
          tach_raw = 1'b1;
          repeat (2) @(negedge clk);
          tach_raw = 1'b0;
          repeat (lo - 5) @(negedge clk);
        end else begin
          repeat (lo) @(negedge clk);
        end
      end
    end
  end

  function automatic int exp_count(int p, int sel, int div);
    int v;
    v = ((sel + 1) * p) / div;
    return (v > 65535) ? 65535 : v;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_valid(output bit got);
    got = 1'b0;
    for (int i = 0; i < 70000; i++) begin
      @(negedge clk);
      if (reading_valid) begin
        got = 1'b1;
        break;
      end
    end
    if (!got) check(1'b0, "timeout", 0, 1);
  endtask

  task automatic configure(int p, int sel, int div, int lim);
    bit g;
    @(negedge clk);
    tper = p;
    pulse_sel = 2'(sel);
    tick_div = div;
    min_limit = 16'(lim);
    wait_valid(g);
    wait_valid(g);
  endtask

  task automatic measure(int exp, string req);
    bit g;
    bit steady;
    logic [15:0] r;
    wait_valid(g);
    r = reading;
    check(reading == 16'(exp), req, reading, exp);
    // R5
    check(slow_fault == (exp > int'(min_limit)), "R5", slow_fault, exp > int'(min_limit));
    // R6: single-cycle strobe, value held afterwards
    steady = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (reading_valid || reading != r) steady = 1'b0;
    end
    check(steady, "R6", reading, r);
  endtask

  initial begin
    bit g;
    int p;
    int s;
    int d;
    int lim;
    int e;
    void'($urandom(32'd7321));
    repeat (4) @(negedge clk);
    // R1 during reset
    check(reading == 0 && !reading_valid && !slow_fault && byte_out == 0, "R1", reading, 0);
    rst = 1'b0;
    @(negedge clk);
    check(reading == 0 && !reading_valid && !slow_fault && byte_out == 0, "R1", reading, 0);

    // R2 R3: every edge-count setting
    for (int k = 0; k < 4; k++) begin
      configure(100, k, 1, 16'hFFFF);
      measure(exp_count(100, k, 1), "R3");
    end

    // R9: sparse reference strobes
    configure(160, 1, 4, 16'hFFFF);
    measure(exp_count(160, 1, 4), "R9");

    // R2 with random patterns, R5 limits
    for (int k = 0; k < 10; k++) begin
      p = 40 + 4 * int'($urandom % 66);
      s = int'($urandom % 4);
      d = (k % 3 == 0) ? 1 : ((k % 3 == 1) ? 2 : 4);
      e = exp_count(p, s, d);
      lim = (k % 2 == 0) ? e - 1 - int'($urandom % 8) : e + int'($urandom % 8);
      if (k == 5) lim = e;
      configure(p, s, d, lim);
      measure(e, "R2");
    end

    // R7: spikes inside the low phase must not count
    glitch_en = 1'b1;
    configure(200, 1, 1, 16'hFFFF);
    measure(400, "R7");
    glitch_en = 1'b0;

    // R8: coherent two-byte read across a newer reading
    configure(400, 3, 1, 16'hFFFF);
    wait_valid(g);
    check(reading == 16'd1600, "R2", reading, 1600);
    rd_lo = 1'b1;
    @(negedge clk);
    rd_lo = 1'b0;
    check(byte_out == 8'h40, "R8", byte_out, 8'h40);
    tper = 1000;
    wait_valid(g);
    wait_valid(g);
    wait_valid(g);
    check(reading == 16'd4000, "R2", reading, 4000);
    rd_hi = 1'b1;
    @(negedge clk);
    rd_hi = 1'b0;
    check(byte_out == 8'h06, "R8", byte_out, 8'h06);
    @(negedge clk);
    rd_hi = 1'b1;
    @(negedge clk);
    rd_hi = 1'b0;
    check(byte_out == 8'h0F, "R8", byte_out, 8'h0F);

    // R4: stopped fan saturates; R5 flags it
    min_limit = 16'h8000;
    tper = 0;
    for (int k = 0; k < 4; k++) begin
      wait_valid(g);
      if (!g || reading == 16'hFFFF) break;
    end
    check(reading == 16'hFFFF, "R4", reading, 16'hFFFF);
    check(slow_fault == 1'b1, "R5", slow_fault, 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule